// File: doc/BRIEF.md
# SD/MMC Command and Response Engine

This engine sends a single SD/MMC command on the CMD line and collects the card's answer. The host loads a 6-bit command index, a 32-bit argument, a 2-bit response-format code and two flags (busy-expected and init-clock), then pulses `start`. The engine drives a 48-bit command frame that ends in a CRC7. It then releases the line and watches it for a response start bit, bounded by a programmable timeout. When a reply arrives, the engine checks its CRC where the format calls for it and stores the reply in four 32-bit response words.

Three sticky flags report the result: done, timeout and CRC error. A pulse on `stat_rd` clears them, as a status read would. A software reset input forces the engine idle and clears the flags and the response words. The engine advances one bit per clock, so the clock is taken to be the card clock itself. Data transfer, clock division and DMA belong to other blocks.

Top module: `sdcmd_engine`

## Requirements
- R1: A command is sent most significant bit first with `cmd_oe` high for all 48 bits. The frame is a start bit 0, a transmission bit 1, the 6-bit index, the 32-bit argument, a CRC7 (generator x^7+x^3+1, register starting at zero) computed over the first 40 bits, and an end bit 1.
- R2: When `init_clk` is set, the line is driven high for INIT_LEN (80) clock cycles before the frame starts. When it is clear, the frame follows `start` directly.
- R3: `cmd_oe` is low whenever no frame is being driven. A 0 on `cmd_in` during the first two clock cycles after the line is released is not taken as a response start bit.
- R4: Format code 1 (48-bit, CRC checked) captures 48 bits. Frame bits 39:8 go to `rsp3`, `rsp2`..`rsp0` become zero, and the done flag is set.
- R5: Format code 2 (136-bit) captures 136 bits. Frame bits 127:0 go to `rsp3` (bits 127:96) down through `rsp0` (bits 31:0). The CRC7 covers frame bits 127:8.
- R6: For codes 1 and 2, a received CRC7 (frame bits 7:1) that does not match the computed one sets the CRC-error flag. Code 3 (48-bit) never sets the CRC-error flag.
- R7: If no start bit is seen within about `tout` cycles of line release, the timeout flag is set, the done flag stays clear and the engine returns idle. `tout` resets to 0x1FFF and is loaded from `tout_din` when `tout_we` is high.
- R8: Format code 0 awaits no response. The done flag is set when the frame ends.
- R9: With `busy_exp` set, `busy` rises after the response is stored and stays high while `dat0_in` is low. `busy` never rises when `busy_exp` is clear.
- R10: A `stat_rd` pulse while idle clears all three flags.
- R11: `soft_rst` returns the engine to idle within one cycle. It drops `cmd_oe` and clears the flags and the response words.
- R12: A `start` pulse while the engine is active is ignored, and the frame in progress is unchanged.
- R13: After reset, `cmd_oe`, `active`, `busy`, all flags and all response words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset: idle and clear state |
| tout_we | input | 1 | Load response timeout limit |
| tout_din | input | TOUT_W (16) | New timeout limit in cycles |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_fmt | input | 2 | 0 none, 1 48-bit with CRC, 2 136-bit, 3 48-bit no CRC |
| busy_exp | input | 1 | Watch DAT0 busy after the response |
| init_clk | input | 1 | Send initialization clocks first |
| stat_rd | input | 1 | Status read; clears the flags |
| cmd_in | input | 1 | CMD line input |
| dat0_in | input | 1 | DAT0 line input (busy when low) |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| active | output | 1 | Engine not idle |
| busy | output | 1 | Card busy after the response |
| flg_done | output | 1 | Sticky: command/response done |
| flg_tout | output | 1 | Sticky: response timeout |
| flg_crc | output | 1 | Sticky: response CRC error |
| rsp0 | output | 32 | Response word, bits 31:0 |
| rsp1 | output | 32 | Response word, bits 63:32 |
| rsp2 | output | 32 | Response word, bits 95:64 |
| rsp3 | output | 32 | Response word, bits 127:96 or 48-bit payload |

## Verification
The assertions check properties on every cycle. The end bit is always driven high with output enable. Output enable is low in the cycle after the transmitter goes idle. A timeout and a completed reply never happen together. Busy rises only straight after a captured reply. A software reset or an idle status read leaves the flags clear, and a software reset also leaves the engine idle. Only the bench scenarios can show the serialized bit order and the CRC7 values. They also cover the exact word placement for both reply lengths, the CRC exemption for format 3, the turnaround rejection, the length of the timeout window and that a stray start is ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    RF_NONE = 2'd0,
    RF_R1   = 2'd1,
    RF_R2   = 2'd2,
    RF_R3   = 2'd3
  } rsp_fmt_e;

  typedef enum logic [1:0] {TX_IDLE, TX_INIT, TX_SEND} tx_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_TURN, RX_HUNT, RX_SHIFT} rx_st_e;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX, ST_BUSY} top_st_e;

  localparam int CMD_BITS   = 48;
  localparam int HDR_BITS   = 40;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  // one serial step of the 7-bit CRC, generator x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdc_tx.sv
module sdc_tx
  import sdc_pkg::*;
#(
  parameter int INIT_LEN = 80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        go,
  input  logic        init_en,
  input  logic [5:0]  index,
  input  logic [31:0] arg,
  output logic        line_out,
  output logic        line_oe,
  output logic        done
);
  localparam int CW = $clog2(INIT_LEN + CMD_BITS + 1);

  tx_st_e                st;
  logic [CW-1:0]         cnt;
  logic [HDR_BITS-1:0]   sr;
  logic [6:0]            crc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st       <= TX_IDLE;
      cnt      <= '0;
      sr       <= '0;
      crc      <= '0;
      line_out <= 1'b1;
      line_oe  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: begin
          line_oe  <= 1'b0;
          line_out <= 1'b1;
          if (go) begin
            sr  <= {2'b01, index, arg};
            cnt <= '0;
            crc <= '0;
            st  <= init_en ? TX_INIT : TX_SEND;
          end
        end
        TX_INIT: begin
          line_oe  <= 1'b1;
          line_out <= 1'b1;
          if (cnt == CW'(INIT_LEN - 1)) begin
            cnt <= '0;
            st  <= TX_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_SEND: begin
          line_oe <= 1'b1;
          cnt     <= cnt + 1'b1;
          if (cnt < CW'(HDR_BITS)) begin
            line_out <= sr[HDR_BITS-1];
            sr       <= {sr[HDR_BITS-2:0], 1'b0};
            crc      <= crc7_step(crc, sr[HDR_BITS-1]);
          end else if (cnt < CW'(CMD_BITS - 1)) begin
            line_out <= crc[6];
            crc      <= {crc[5:0], 1'b0};
          end else begin
            line_out <= 1'b1;
            done     <= 1'b1;
            st       <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R1: the frame's final bit is a driven 1
  a_r1_end_bit_high: assert property (@(posedge clk) disable iff (rst)
    done |-> (line_out && line_oe));

  // R3: once idle the line is released on the next cycle
  a_r3_idle_release: assert property (@(posedge clk) disable iff (rst)
    (st == TX_IDLE) |=> !line_oe);

endmodule

// File: rtl/sdc_rx.sv
module sdc_rx
  import sdc_pkg::*;
#(
  parameter int TURN   = 2,
  parameter int TOUT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              arm,
  input  logic              long_rsp,
  input  logic              line_in,
  input  logic [TOUT_W-1:0] tout_lim,
  output logic              done,
  output logic              tout,
  output logic              crc_ok,
  output logic [127:0]      bits
);
  localparam int CW = $clog2(LONG_BITS + 1);

  rx_st_e               st;
  logic [CW-1:0]        cnt;
  logic [TOUT_W-1:0]    tmr;
  logic [LONG_BITS-1:0] sh;
  logic [6:0]           crc;
  logic                 islong;

  logic [CW-1:0] last_pos, crc_lo, crc_hi;
  logic          feed;

  always_comb begin
    last_pos = islong ? CW'(LONG_BITS - 1) : CW'(SHORT_BITS - 1);
    crc_lo   = islong ? CW'(8) : CW'(1);
    crc_hi   = last_pos - CW'(8);
    feed     = (cnt >= crc_lo) && (cnt <= crc_hi);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      tmr    <= '0;
      sh     <= '0;
      crc    <= '0;
      islong <= 1'b0;
      done   <= 1'b0;
      tout   <= 1'b0;
      crc_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      tout <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (arm) begin
            st     <= RX_TURN;
            cnt    <= '0;
            tmr    <= '0;
            crc    <= '0;
            islong <= long_rsp;
          end
        end
        RX_TURN: begin
          tmr <= tmr + 1'b1;
          if (cnt == CW'(TURN - 1)) begin
            cnt <= '0;
            st  <= RX_HUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HUNT: begin
          tmr <= tmr + 1'b1;
          if (!line_in) begin
            sh  <= '0;
            cnt <= CW'(1);
            st  <= RX_SHIFT;
          end else if (tmr >= tout_lim) begin
            tout <= 1'b1;
            st   <= RX_IDLE;
          end
        end
        RX_SHIFT: begin
          sh  <= {sh[LONG_BITS-2:0], line_in};
          cnt <= cnt + 1'b1;
          if (feed) crc <= crc7_step(crc, line_in);
          if (cnt == last_pos) begin
            done   <= 1'b1;
            crc_ok <= (crc == sh[6:0]);
            st     <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign bits = sh[127:0];

  // R7: a reply and a timeout are never reported together
  a_r7_excl_events: assert property (@(posedge clk) disable iff (rst)
    !(done && tout));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdc_pkg::*;
#(
  parameter int              INIT_LEN = 80,
  parameter int              TURN     = 2,
  parameter int              TOUT_W   = 16,
  parameter logic [TOUT_W-1:0] TOUT_RST = TOUT_W'(16'h1FFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              tout_we,
  input  logic [TOUT_W-1:0] tout_din,
  input  logic              start,
  input  logic [5:0]        cmd_index,
  input  logic [31:0]       cmd_arg,
  input  logic [1:0]        rsp_fmt,
  input  logic              busy_exp,
  input  logic              init_clk,
  input  logic              stat_rd,
  input  logic              cmd_in,
  input  logic              dat0_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              active,
  output logic              busy,
  output logic              flg_done,
  output logic              flg_tout,
  output logic              flg_crc,
  output logic [31:0]       rsp0,
  output logic [31:0]       rsp1,
  output logic [31:0]       rsp2,
  output logic [31:0]       rsp3
);
  localparam int NWORDS = 4;

  top_st_e                st;
  rsp_fmt_e               fmt_q;
  logic                   bexp_q;
  logic [TOUT_W-1:0]      tout_lim;
  logic [NWORDS-1:0][31:0] rsp_q;

  logic         tx_go, tx_done, rx_arm;
  logic         rx_done, rx_tout, rx_crc_ok;
  logic [127:0] rx_bits;

  assign tx_go  = (st == ST_IDLE) && start && !soft_rst;
  assign rx_arm = (st == ST_TX) && tx_done && (fmt_q != RF_NONE);

  sdc_tx #(.INIT_LEN(INIT_LEN)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_rst),
    .go       (tx_go),
    .init_en  (init_clk),
    .index    (cmd_index),
    .arg      (cmd_arg),
    .line_out (cmd_out),
    .line_oe  (cmd_oe),
    .done     (tx_done)
  );

  sdc_rx #(.TURN(TURN), .TOUT_W(TOUT_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_rst),
    .arm      (rx_arm),
    .long_rsp (fmt_q == RF_R2),
    .line_in  (cmd_in),
    .tout_lim (tout_lim),
    .done     (rx_done),
    .tout     (rx_tout),
    .crc_ok   (rx_crc_ok),
    .bits     (rx_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tout_lim <= TOUT_RST;
    end else if (tout_we) begin
      tout_lim <= tout_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st       <= ST_IDLE;
      fmt_q    <= RF_NONE;
      bexp_q   <= 1'b0;
      flg_done <= 1'b0;
      flg_tout <= 1'b0;
      flg_crc  <= 1'b0;
      rsp_q    <= '0;
    end else begin
      if (stat_rd) begin
        flg_done <= 1'b0;
        flg_tout <= 1'b0;
        flg_crc  <= 1'b0;
      end
      case (st)
        ST_IDLE: begin
          if (start) begin
            fmt_q  <= rsp_fmt_e'(rsp_fmt);
            bexp_q <= busy_exp;
            st     <= ST_TX;
          end
        end
        ST_TX: begin
          if (tx_done) begin
            if (fmt_q == RF_NONE) begin
              flg_done <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (rx_tout) begin
            flg_tout <= 1'b1;
            st       <= ST_IDLE;
          end else if (rx_done) begin
            flg_done <= 1'b1;
            if ((fmt_q != RF_R3) && !rx_crc_ok) flg_crc <= 1'b1;
            if (fmt_q == RF_R2) begin
              rsp_q <= rx_bits;
            end else begin
              rsp_q    <= '0;
              rsp_q[3] <= rx_bits[39:8];
            end
            st <= bexp_q ? ST_BUSY : ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (dat0_in) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign active = (st != ST_IDLE);
  assign busy   = (st == ST_BUSY);
  assign rsp0   = rsp_q[0];
  assign rsp1   = rsp_q[1];
  assign rsp2   = rsp_q[2];
  assign rsp3   = rsp_q[3];

  // R11: software reset idles the engine and clears the flags
  a_r11_soft_idle: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!active && !cmd_oe && !flg_done && !flg_tout && !flg_crc));

  // R10: reading status while idle clears every flag
  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !active && !soft_rst) |=> (!flg_done && !flg_tout && !flg_crc));

  // R9: busy only follows a freshly captured reply
  a_r9_busy_after_rsp: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(rx_done));

  // R7: a receiver timeout lands in the sticky flag and idles the engine
  a_r7_tout_flag: assert property (@(posedge clk) disable iff (rst || soft_rst)
    rx_tout |=> (flg_tout && !active));

endmodule

// File: tb/tb_sdcmd_engine.sv
module tb_sdcmd_engine;
  localparam int INIT_LEN = 80;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, soft_rst = 1'b0, tout_we = 1'b0, start = 1'b0;
  logic [15:0] tout_din = '0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  rsp_fmt = '0;
  logic        busy_exp = 1'b0, init_clk = 1'b0, stat_rd = 1'b0;
  logic        cmd_in = 1'b1, dat0_in = 1'b1;
  logic        cmd_out, cmd_oe, active, busy, flg_done, flg_tout, flg_crc;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;

  sdcmd_engine dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .tout_we(tout_we), .tout_din(tout_din),
    .start(start), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_fmt(rsp_fmt),
    .busy_exp(busy_exp), .init_clk(init_clk), .stat_rd(stat_rd), .cmd_in(cmd_in),
    .dat0_in(dat0_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .active(active), .busy(busy),
    .flg_done(flg_done), .flg_tout(flg_tout), .flg_crc(flg_crc),
    .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [199:0] cap;
  int ncap;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // CRC7 by long division of the message times x^7 by 0x89
  function automatic logic [6:0] bcrc(input logic [127:0] m, input int n);
    logic [7:0] rem;
    rem = '0;
    for (int i = n - 1; i >= -7; i--) begin
      rem = {rem[6:0], (i >= 0) ? m[i] : 1'b0};
      if (rem[7]) rem = rem ^ 8'h89;
    end
    return rem[6:0];
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, bcrc({88'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] resp48(input logic [5:0] idx, input logic [31:0] stat);
    logic [39:0] h;
    h = {2'b00, idx, stat};
    return {88'b0, h, bcrc({88'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] resp136(input logic [119:0] c);
    return {2'b00, 6'h3F, c, bcrc({8'b0, c}, 120), 1'b1};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue a command and collect the driven bits; returns at the first released cycle
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] fmt,
                       input bit bexp, input bit ini, input int restart_at);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; rsp_fmt = fmt; busy_exp = bexp; init_clk = ini;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cap = '0; ncap = 0;
    for (int k = 0; k < 400; k++) begin
      if (cmd_oe) begin
        cap = {cap[198:0], cmd_out};
        ncap++;
        seen = 1'b1;
      end else if (seen) begin
        start = 1'b0;
        cmd_index = idx;
        break;
      end
      start = (k == restart_at);
      if (k == restart_at) cmd_index = 6'h2A;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic send_rsp(input logic [135:0] fr, input int len, input int gap, input bit gv);
    for (int g = 0; g < gap; g++) begin
      cmd_in = gv;
      @(negedge clk);
    end
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = fr[i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic read_status();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  // every-cycle comparison: line drive and busy only exist inside an active command
  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_chk++;
      if ((cmd_oe || busy) && !active) begin
        n_bad++;
        $display("FAIL R3 monitor: cmd_oe=%b busy=%b active=%b expected active=1",
                 cmd_oe, busy, active);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [135:0] fr;
    logic [119:0] c;
    bit ones;
    int t;

    wait_n(5);
    chk({cmd_oe, active, busy, flg_done, flg_tout, flg_crc} == 6'b0, "R13", "outputs in reset",
        {cmd_oe, active, busy, flg_done, flg_tout, flg_crc}, 0);
    rst = 1'b0;
    wait_n(2);
    chk({rsp3, rsp2, rsp1, rsp0} == 128'b0, "R13", "response words after reset",
        {rsp3, rsp2, rsp1, rsp0}, 0);
    chk(bcrc({88'b0, 40'h4000000000}, 40) == 7'h4A, "R1", "bench CRC7 of index 0",
        bcrc({88'b0, 40'h4000000000}, 40), 7'h4A);

    // index 0 with init clocks, no response
    issue(6'd0, 32'h0, 2'd0, 1'b0, 1'b1, -1);
    chk(ncap == INIT_LEN + 48, "R2", "driven cycles with init", ncap, INIT_LEN + 48);
    ones = 1'b1;
    for (int i = 48; i < INIT_LEN + 48; i++) if (!cap[i]) ones = 1'b0;
    chk(ones, "R2", "init cycles all high", cap[127:48], {80{1'b1}});
    chk(cap[47:0] == cmd_frame(6'd0, 32'h0), "R1", "index 0 frame", cap[47:0], cmd_frame(6'd0, 32'h0));
    chk(flg_done && !active, "R8", "done without response", {flg_done, active}, 2'b10);
    read_status();
    chk({flg_done, flg_tout, flg_crc} == 3'b0, "R10", "flags after read",
        {flg_done, flg_tout, flg_crc}, 0);

    // 136-bit response
    c = 120'h1D_4142_4344_4546_4748_494A_4B4C_4D4E;
    issue(6'd2, 32'h0, 2'd2, 1'b0, 1'b0, -1);
    chk(ncap == 48, "R2", "no init cycles", ncap, 48);
    chk(cap[47:0] == cmd_frame(6'd2, 32'h0), "R1", "index 2 frame", cap[47:0], cmd_frame(6'd2, 32'h0));
    fr = resp136(c);
    send_rsp(fr, 136, 2, 1'b1);
    wait_n(3);
    chk({rsp3, rsp2, rsp1, rsp0} == fr[127:0], "R5", "136-bit words", {rsp3, rsp2, rsp1, rsp0}, fr[127:0]);
    chk(flg_done && !flg_crc && !active, "R5", "136-bit status", {flg_done, flg_crc, active}, 3'b100);
    read_status();

    // 48-bit response, CRC checked
    issue(6'd8, 32'h0000_01AA, 2'd1, 1'b0, 1'b0, -1);
    chk(cap[47:0] == 48'h48_0000_01AA_87, "R1", "index 8 frame", cap[47:0], 48'h48_0000_01AA_87);
    send_rsp(resp48(6'd8, 32'h0000_01AA), 48, 2, 1'b1);
    wait_n(3);
    chk(rsp3 == 32'h0000_01AA, "R4", "48-bit payload", rsp3, 32'h0000_01AA);
    chk({rsp2, rsp1, rsp0} == 96'b0, "R4", "lower words cleared", {rsp2, rsp1, rsp0}, 0);
    chk(flg_done && !flg_crc && !busy, "R4", "48-bit status", {flg_done, flg_crc, busy}, 3'b100);
    read_status();

    // bad CRC, format 1
    fr = resp48(6'd13, 32'h0000_0900) ^ 136'h2;
    issue(6'd13, 32'h0001_0000, 2'd1, 1'b0, 1'b0, -1);
    send_rsp(fr, 48, 2, 1'b1);
    wait_n(3);
    chk(flg_crc && flg_done, "R6", "CRC error flagged", {flg_crc, flg_done}, 2'b11);
    read_status();

    // bad CRC, format 3: ignored
    fr = resp48(6'h3F, 32'h80FF_8000) ^ 136'h2;
    issue(6'd41, 32'h0, 2'd3, 1'b0, 1'b0, -1);
    send_rsp(fr, 48, 2, 1'b1);
    wait_n(3);
    chk(!flg_crc && flg_done, "R6", "format 3 skips CRC", {flg_crc, flg_done}, 2'b01);
    chk(rsp3 == 32'h80FF_8000, "R4", "format 3 payload", rsp3, 32'h80FF_8000);
    read_status();

    // turnaround: zeros right after release must be ignored
    issue(6'd7, 32'h1234_0000, 2'd1, 1'b0, 1'b0, -1);
    send_rsp(resp48(6'd7, 32'h0000_0700), 48, 2, 1'b0);
    wait_n(3);
    chk(rsp3 == 32'h0000_0700 && !flg_crc, "R3", "turnaround zeros ignored",
        {flg_crc, rsp3}, {1'b0, 32'h0000_0700});
    read_status();

    // busy after response
    dat0_in = 1'b0;
    issue(6'd12, 32'h0, 2'd1, 1'b1, 1'b0, -1);
    send_rsp(resp48(6'd12, 32'h0000_0B00), 48, 2, 1'b1);
    wait_n(3);
    chk(busy && active, "R9", "busy while DAT0 low", {busy, active}, 2'b11);
    wait_n(10);
    chk(busy, "R9", "busy held", busy, 1'b1);
    dat0_in = 1'b1;
    wait_n(2);
    chk(!busy && !active && flg_done, "R9", "busy released", {busy, active, flg_done}, 3'b001);
    read_status();

    // programmed timeout
    @(negedge clk); tout_din = 16'd40; tout_we = 1'b1;
    @(negedge clk); tout_we = 1'b0;
    issue(6'd55, 32'h0, 2'd1, 1'b0, 1'b0, -1);
    t = -1;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (flg_tout) begin t = k; break; end
    end
    chk(t >= 38 && t <= 46, "R7", "short timeout window", t, 42);
    chk(!flg_done && !active, "R7", "timeout state", {flg_done, active}, 2'b00);
    read_status();

    // default timeout after reset
    @(negedge clk); rst = 1'b1;
    wait_n(2); rst = 1'b0;
    issue(6'd55, 32'h0, 2'd1, 1'b0, 1'b0, -1);
    t = -1;
    for (int k = 1; k < 9000; k++) begin
      @(negedge clk);
      if (flg_tout) begin t = k; break; end
    end
    chk(t >= 8189 && t <= 8197, "R7", "reset timeout window", t, 8193);
    read_status();

    // stray start during a frame
    issue(6'd6, 32'h0300_0001, 2'd0, 1'b0, 1'b0, 10);
    chk(ncap == 48 && cap[47:0] == cmd_frame(6'd6, 32'h0300_0001), "R12", "frame unchanged",
        cap[47:0], cmd_frame(6'd6, 32'h0300_0001));
    wait_n(3);
    chk(!active && !cmd_oe, "R12", "no second command", {active, cmd_oe}, 2'b00);

    // software reset mid-command, with a flag and response word set
    issue(6'd8, 32'h0000_01AA, 2'd1, 1'b0, 1'b0, -1);
    send_rsp(resp48(6'd8, 32'h0000_01AA), 48, 2, 1'b1);
    wait_n(3);
    @(negedge clk);
    cmd_index = 6'd17; rsp_fmt = 2'd1; init_clk = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_n(20);
    chk(cmd_oe && active, "R11", "engine busy before reset", {cmd_oe, active}, 2'b11);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk({active, cmd_oe, flg_done, flg_tout, flg_crc} == 5'b0, "R11", "idle after soft reset",
        {active, cmd_oe, flg_done, flg_tout, flg_crc}, 0);
    chk(rsp3 == 32'b0, "R11", "response cleared", rsp3, 0);
    wait_n(100);
    chk(!cmd_oe && !active, "R11", "stays idle", {cmd_oe, active}, 2'b00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule